// File: doc/BRIEF.md
# Video Blanking Timing Generator

This block produces the two active-low blanking signals of a console video encoder, a horizontal one and a vertical one. It also produces a one-clock frame-start strobe and the current line number. It advances once for every master-clock tick: `tick` is a one-cycle enable, sampled on the rising edge of the system clock. A horizontal counter steps through the master cycles of each line. A line counter steps through the lines of each frame.

By default a line is 1365 master cycles. Horizontal blanking is low for the first 237 of them. Vertical blanking is low for three whole lines, 4095 master cycles. Its falling edge and its rising edge both sit a fixed 30 master cycles after a horizontal blanking falling edge. A frame-length control input chooses between 262 lines (357630 master cycles) and 263 lines (358995 master cycles). This input is taken only at the boundary between frames. A two-bit clock-select input is present for compatibility and leaves the timing untouched.

After synchronous reset the generator stands at the horizontal blanking falling edge of line 0. Horizontal blanking is low and vertical blanking is high. Vertical blanking falls 30 ticks later, and the frame-start strobe marks that edge.

Top module: `blank_timing_gen`

## Requirements
- R1: While and just after synchronous reset, `hBlankN` is 0, `vBlankN` is 1, `frameStart` is 0 and `lineNum` is 0.
- R2: `hBlankN` is 0 for the first HBLANK_LOW ticks of every line and 1 for the remaining LINE_CYCLES-HBLANK_LOW ticks. It falls again every LINE_CYCLES ticks.
- R3: `vBlankN` falls when line 0 reaches horizontal position VEDGE_OFFSET. It stays 0 for exactly VBLANK_LINES*LINE_CYCLES ticks and rises when line VBLANK_LINES reaches the same position.
- R4: Every transition of `vBlankN` occurs exactly VEDGE_OFFSET ticks after the most recent falling edge of `hBlankN`.
- R5: With the frame mode at 0, a frame is SHORT_LINES lines, so `frameStart` repeats every SHORT_LINES*LINE_CYCLES ticks.
- R6: With the frame mode at 1, a frame is SHORT_LINES+1 lines, exactly one line longer.
- R7: `longFrame` is captured during reset and on the tick that wraps the last line back to line 0. A change at any other time does not alter the length of the frame in progress.
- R8: `frameStart` is a single clock cycle high in the same cycle that `vBlankN` is first seen low, and at no other time.
- R9: `clkSel` has no effect on any output.
- R10: Outputs change only after a clock edge at which `tick` is 1. With `tick` at 0 they hold their values.
- R11: `lineNum` counts 0, 1, ... up to the last line of the frame, increments on the tick that ends each line, and returns to 0 after the last line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Master-clock enable, one per master cycle |
| longFrame | input | 1 | Frame mode: 0 short frame, 1 one line longer |
| clkSel | input | 2 | Clock-select bits, accepted and ignored |
| hBlankN | output | 1 | Horizontal blanking, active low |
| vBlankN | output | 1 | Vertical blanking, active low |
| frameStart | output | 1 | One-cycle strobe at the vertical blanking falling edge |
| lineNum | output | $clog2(SHORT_LINES+1) | Current line within the frame |

## Verification
The bench builds the generator with 16-tick lines, 4 ticks of horizontal blanking, a vertical edge offset of 3, 5-line short frames and 2 blanking lines. A whole frame is then 80 or 96 ticks. These values make the position of every vertical edge against the horizontal fall, the one-line difference between frame modes and the frame-boundary capture of the mode input observable many times over in a short run. Because the offset is smaller than the horizontal low time, every vertical edge also falls inside horizontal blanking, as in the full-size timing. Stimulus runs with continuous ticks, with ticks separated by idle clocks, and with the clock-select input changing each tick. Each sample is compared against a position model derived from the requirements.

// File: rtl/blank_timing_pkg.sv
`timescale 1ns/1ps
package blank_timing_pkg;

  // Single-clock strobes from the horizontal control to the line datapath.
  typedef struct packed {
    logic lineWrap;  // tick that ends the current line
    logic hRise;     // tick that ends horizontal blanking
    logic vEdge;     // tick that reaches the vertical edge position
  } blankStrobes_t;

endpackage

// File: rtl/blank_hctrl.sv
`timescale 1ns/1ps
module blank_hctrl
  import blank_timing_pkg::*;
#(
  parameter int LINE_CYCLES  = 1365,
  parameter int HBLANK_LOW   = 237,
  parameter int VEDGE_OFFSET = 30
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  output blankStrobes_t strobes
);

  localparam int HW = $clog2(LINE_CYCLES);
  localparam logic [HW-1:0] H_LAST   = HW'(LINE_CYCLES - 1);
  localparam logic [HW-1:0] H_RISE   = HW'(HBLANK_LOW - 1);
  localparam logic [HW-1:0] H_VEDGE  = HW'(VEDGE_OFFSET - 1);

  logic [HW-1:0] hCount;
  logic          atLast;

  assign atLast = (hCount == H_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      hCount <= '0;
    end else if (tick) begin
      hCount <= atLast ? '0 : hCount + 1'b1;
    end
  end

  always_comb begin
    strobes.lineWrap = tick && atLast;
    strobes.hRise    = tick && (hCount == H_RISE);
    strobes.vEdge    = tick && (hCount == H_VEDGE);
  end

endmodule

// File: rtl/blank_vpath.sv
`timescale 1ns/1ps
module blank_vpath
  import blank_timing_pkg::*;
#(
  parameter int SHORT_LINES  = 262,
  parameter int VBLANK_LINES = 3,
  localparam int LW = $clog2(SHORT_LINES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          longFrame,
  input  blankStrobes_t strobes,
  output logic          hBlankN,
  output logic          vBlankN,
  output logic          frameStart,
  output logic [LW-1:0] lineNum
);

  localparam logic [LW-1:0] LAST_SHORT = LW'(SHORT_LINES - 1);
  localparam logic [LW-1:0] LAST_LONG  = LW'(SHORT_LINES);
  localparam logic [LW-1:0] V_RISE_LN  = LW'(VBLANK_LINES);

  logic          longMode;
  logic [LW-1:0] lastLine;

  assign lastLine = longMode ? LAST_LONG : LAST_SHORT;

  always_ff @(posedge clk) begin
    if (rst) begin
      lineNum    <= '0;
      longMode   <= longFrame;
      hBlankN    <= 1'b0;
      vBlankN    <= 1'b1;
      frameStart <= 1'b0;
    end else begin
      frameStart <= 1'b0;
      if (strobes.lineWrap) begin
        hBlankN <= 1'b0;
        if (lineNum == lastLine) begin
          lineNum  <= '0;
          longMode <= longFrame;
        end else begin
          lineNum <= lineNum + 1'b1;
        end
      end
      if (strobes.hRise) begin
        hBlankN <= 1'b1;
      end
      if (strobes.vEdge) begin
        if (lineNum == '0) begin
          vBlankN    <= 1'b0;
          frameStart <= 1'b1;
        end else if (lineNum == V_RISE_LN) begin
          vBlankN <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/blank_timing_gen.sv
`timescale 1ns/1ps
module blank_timing_gen
  import blank_timing_pkg::*;
#(
  parameter int LINE_CYCLES  = 1365,
  parameter int HBLANK_LOW   = 237,
  parameter int VEDGE_OFFSET = 30,
  parameter int SHORT_LINES  = 262,
  parameter int VBLANK_LINES = 3,
  localparam int LW = $clog2(SHORT_LINES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          longFrame,
  input  logic [1:0]    clkSel,
  output logic          hBlankN,
  output logic          vBlankN,
  output logic          frameStart,
  output logic [LW-1:0] lineNum
);

  blankStrobes_t strobes;
  logic          unusedClkSel;

  // Clock-select bits are accepted but leave the timing untouched.
  assign unusedClkSel = ^clkSel;

  blank_hctrl #(
    .LINE_CYCLES (LINE_CYCLES),
    .HBLANK_LOW  (HBLANK_LOW),
    .VEDGE_OFFSET(VEDGE_OFFSET)
  ) u_hctrl (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .strobes(strobes)
  );

  blank_vpath #(
    .SHORT_LINES (SHORT_LINES),
    .VBLANK_LINES(VBLANK_LINES)
  ) u_vpath (
    .clk       (clk),
    .rst       (rst),
    .longFrame (longFrame),
    .strobes   (strobes),
    .hBlankN   (hBlankN),
    .vBlankN   (vBlankN),
    .frameStart(frameStart),
    .lineNum   (lineNum)
  );

endmodule

// File: rtl/blank_timing_chk.sv
`timescale 1ns/1ps
module blank_timing_chk #(
  parameter int LINE_CYCLES  = 1365,
  parameter int VEDGE_OFFSET = 30,
  parameter int SHORT_LINES  = 262,
  localparam int LW = $clog2(SHORT_LINES + 1),
  localparam int CW = $clog2(LINE_CYCLES + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic          hBlankN,
  input logic          vBlankN,
  input logic          frameStart,
  input logic [LW-1:0] lineNum
);

  logic          prevH;
  logic [CW-1:0] sinceFall;
  logic          fellNow;

  assign fellNow = prevH && !hBlankN;

  // Ticks counted since hBlankN was last seen falling.
  always_ff @(posedge clk) begin
    if (rst) begin
      prevH     <= 1'b0;
      sinceFall <= '0;
    end else begin
      prevH <= hBlankN;
      if (fellNow) begin
        sinceFall <= tick ? CW'(1) : '0;
      end else if (tick) begin
        sinceFall <= sinceFall + 1'b1;
      end
    end
  end

  a_r4_vedge_offset: assert property (@(posedge clk) disable iff (rst)
    !$stable(vBlankN) |-> (sinceFall == CW'(VEDGE_OFFSET)));

  a_r8_start_on_vfall: assert property (@(posedge clk) disable iff (rst)
    frameStart |-> $fell(vBlankN));

  a_r8_start_single: assert property (@(posedge clk) disable iff (rst)
    frameStart |=> !frameStart);

  a_r10_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(hBlankN) && $stable(vBlankN) && $stable(lineNum)));

  a_r11_line_range: assert property (@(posedge clk) disable iff (rst)
    lineNum <= LW'(SHORT_LINES));

endmodule

bind blank_timing_gen blank_timing_chk #(
  .LINE_CYCLES (LINE_CYCLES),
  .VEDGE_OFFSET(VEDGE_OFFSET),
  .SHORT_LINES (SHORT_LINES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .hBlankN   (hBlankN),
  .vBlankN   (vBlankN),
  .frameStart(frameStart),
  .lineNum   (lineNum)
);

// File: tb/blank_timing_gen_tb.sv
`timescale 1ns/1ps
module blank_timing_gen_tb;

  localparam int LC = 16;
  localparam int HL = 4;
  localparam int VO = 3;
  localparam int SL = 5;
  localparam int VL = 2;
  localparam int LW = $clog2(SL + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick = 1'b0;
  logic          longFrame = 1'b0;
  logic [1:0]    clkSel = 2'b00;
  logic          hBlankN;
  logic          vBlankN;
  logic          frameStart;
  logic [LW-1:0] lineNum;

  int  tests = 0;
  int  fails = 0;
  int  mh = 0;
  int  mline = 0;
  bit  mMode = 1'b0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  blank_timing_gen #(
    .LINE_CYCLES (LC),
    .HBLANK_LOW  (HL),
    .VEDGE_OFFSET(VO),
    .SHORT_LINES (SL),
    .VBLANK_LINES(VL)
  ) u_dut (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .longFrame (longFrame),
    .clkSel    (clkSel),
    .hBlankN   (hBlankN),
    .vBlankN   (vBlankN),
    .frameStart(frameStart),
    .lineNum   (lineNum)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Position model from the requirements: one step per tick.
  task automatic modelStep();
    int lastLn;
    lastLn = mMode ? SL : SL - 1;
    if (mh == LC - 1) begin
      mh = 0;
      if (mline == lastLn) begin
        mline = 0;
        mMode = longFrame;
      end else begin
        mline++;
      end
    end else begin
      mh++;
    end
  endtask

  function automatic int expV();
    if ((mline == 0 && mh >= VO) || (mline >= 1 && mline < VL) ||
        (mline == VL && mh < VO))
      return 0;
    return 1;
  endfunction

  // One clock with tick = t; compare outputs against the model at negedge.
  task automatic cycle(input bit t, input string tag);
    tick = t;
    if (t) modelStep();
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0;
    check({tag, " R2 hBlankN"}, int'(hBlankN), (mh >= HL) ? 1 : 0);
    check({tag, " R3/R4 vBlankN"}, int'(vBlankN), expV());
    check({tag, " R8 frameStart"}, int'(frameStart),
          (t && mline == 0 && mh == VO) ? 1 : 0);
    check({tag, " R11 lineNum"}, int'(lineNum), mline);
  endtask

  task automatic runUntilFrame(input string tag, output int n);
    n = 0;
    do begin
      cycle(1'b1, tag);
      n++;
    end while (!frameStart && n < 1000);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    longFrame = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 hBlankN in reset", int'(hBlankN), 0);
    rst = 1'b0;
    mh = 0; mline = 0; mMode = 1'b0;
    @(negedge clk);
    check("R1 hBlankN", int'(hBlankN), 0);
    check("R1 vBlankN", int'(vBlankN), 1);
    check("R1 frameStart", int'(frameStart), 0);
    check("R1 lineNum", int'(lineNum), 0);
  endtask

  task automatic t_short();
    int n;
    runUntilFrame("R3 first frame", n);
    check("R3 first vBlankN fall tick", n, VO);
    runUntilFrame("R5 short frame", n);
    check("R5 short frame period", n, SL * LC);
    runUntilFrame("R5 short frame 2", n);
    check("R5 short frame period 2", n, SL * LC);
  endtask

  task automatic t_sparse();
    for (int i = 0; i < 3 * SL * LC; i++) begin
      cycle(1'b1, "R10 sparse");
      cycle(1'b0, "R10 idle");
      cycle(1'b0, "R10 idle");
    end
  endtask

  task automatic t_long();
    int n;
    runUntilFrame("R7 align", n);
    longFrame = 1'b1;
    runUntilFrame("R7 mid-frame set", n);
    check("R7 frame after mid-frame set stays short", n, SL * LC);
    runUntilFrame("R6 long frame", n);
    check("R6 long frame period", n, (SL + 1) * LC);
    longFrame = 1'b0;
    runUntilFrame("R7 mid-frame clear", n);
    check("R7 frame after mid-frame clear stays long", n, (SL + 1) * LC);
    runUntilFrame("R5 back to short", n);
    check("R5 short period after clear", n, SL * LC);
  endtask

  task automatic t_clksel();
    int n;
    for (int f = 0; f < 2; f++) begin
      n = 0;
      do begin
        clkSel = clkSel + 2'd1;
        cycle(1'b1, "R9 clkSel");
        n++;
      end while (!frameStart && n < 1000);
      if (f == 1) check("R9 period with clkSel changing", n, SL * LC);
    end
    longFrame = 1'b1;
    runUntilFrame("R9 long", n);
    for (int f = 0; f < 2; f++) begin
      n = 0;
      do begin
        clkSel = 2'(f * 3);
        cycle(1'b1, "R9 clkSel long");
        n++;
      end while (!frameStart && n < 1000);
      check("R9 long period with fixed clkSel", n, (SL + 1) * LC);
    end
    longFrame = 1'b0;
  endtask

  initial begin
    t_reset();
    t_short();
    t_sparse();
    t_long();
    t_clksel();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R10 watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule